// File: doc/BRIEF.md
# Three-Register Management Controller Responder

This block is the controller-side end of a byte-wide, three-register host interface for management messages. A host reaches a data register, a control/status register and a flags register through a small register port. It writes a control code and sets the busy flag. The responder then works on the command for a fixed number of cycles, writes back a status code and clears busy. Request bytes written by the host go into a receive FIFO, which local logic drains. Response bytes that local logic pushes into a transmit FIFO are handed to the host one at a time.

The host paces itself on three flags. The accept-ready flag says a request byte may be written, the response-ready flag says response bytes can be fetched, and busy says a command is still being processed. A completion code is left in the data register at the end of each phase. A control code that arrives in the wrong phase, or that is not defined at all, ends the exchange and returns the responder to idle with both FIFOs emptied. Register offsets: 0 is data, 1 is control (write) and status (read), 2 is flags, and 3 reads as zero.

Top module: `smic_responder`

## Requirements
- R1: After reset the status register reads 0xC0, the data register reads 0x00 and the flags register reads 0x40, or 0x44 while `evt_pending` is high.
- R2: A host write to the flags register with bit 0 set, made while busy is clear, sets busy (flags bit 0). Busy then stays set for exactly LATENCY cycles and clears by itself. A flags write with bit 0 clear changes nothing.
- R3: After each write-start (0x41), write-next (0x42), write-end (0x43) and read-start (0x44) command, the status reads as the control code with bit 7 set.
- R4: Write-start and write-next push the data register byte into the receive FIFO, and the bytes reach `rx_data` in the order written. Accept-ready (flags bit 6) is low while busy is set and while the receive FIFO is full.
- R5: A write-end that stays within the FIFO depth pushes the last byte, leaves completion code 0x00 in the data register and pulses `req_end` for one cycle.
- R6: If any byte of a request finds the receive FIFO full, that byte is dropped. The write-end then leaves 0x05 in the data register, empties the receive FIFO and gives no `req_end` pulse.
- R7: A control code outside 0x40 to 0x46 leaves status = code | 0x80 and data 0x04, and returns the responder to idle with both FIFOs emptied.
- R8: Response-ready (flags bit 7) rises once a request has been accepted and local logic has pushed a byte marked `tx_last` while busy is clear. It stays high until the last response byte is handed out.
- R9: Read-start hands the first response byte to the data register. Each read-next hands the following byte, with status 0xC5 if more bytes follow and 0xC6 if it is the last byte.
- R10: A read-end after the last byte leaves status 0xC0 and data 0x00, and clears response-ready.
- R11: Get-status (0x40) answers 0xC0 and does not change the current phase.
- R12: A defined control code received in a phase where it does not apply leaves data 0x02 and returns the responder to idle with both FIFOs emptied.
- R13: Flags bit 2 follows `evt_pending`. Bits 5, 4, 3 and 1 always read 0, so the flags register never reads 0xFF.
- R14: Host writes to the data or control register while busy is set are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_addr | input | 2 | Register select: 0 data, 1 control/status, 2 flags |
| host_wr | input | 1 | Host write strobe |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Register selected by host_addr (combinational) |
| evt_pending | input | 1 | Local logic has an unsolicited message queued |
| rx_data | output | 8 | Head byte of the receive FIFO |
| rx_valid | output | 1 | Receive FIFO not empty |
| rx_pop | input | 1 | Local logic takes the head byte |
| req_end | output | 1 | One-cycle pulse: a complete request has been accepted |
| tx_data | input | 8 | Response byte from local logic |
| tx_last | input | 1 | Marks the final byte of a response |
| tx_push | input | 1 | Push tx_data into the transmit FIFO |
| tx_full | output | 1 | Transmit FIFO full |

## Verification
The bench builds the responder with a four-entry receive FIFO, an eight-entry transmit FIFO and a five-cycle latency. The small receive depth lets a six-byte request fill the FIFO, so the buffer-full completion and the drop of later bytes can be reached. The five-cycle latency leaves room to make host writes while busy is set and to count the busy window exactly. Local logic is played by the bench, which pops request bytes and pushes responses of several lengths.

// File: rtl/smic_resp_pkg.sv
package smic_resp_pkg;

    localparam int BYTE_W = 8;

    // control codes written by the host
    localparam logic [BYTE_W-1:0] CC_GET      = 8'h40;
    localparam logic [BYTE_W-1:0] CC_WR_START = 8'h41;
    localparam logic [BYTE_W-1:0] CC_WR_NEXT  = 8'h42;
    localparam logic [BYTE_W-1:0] CC_WR_END   = 8'h43;
    localparam logic [BYTE_W-1:0] CC_RD_START = 8'h44;
    localparam logic [BYTE_W-1:0] CC_RD_NEXT  = 8'h45;
    localparam logic [BYTE_W-1:0] CC_RD_END   = 8'h46;

    localparam logic [BYTE_W-1:0] ST_MARK    = 8'h80;
    localparam logic [BYTE_W-1:0] ST_READY   = 8'hC0;
    localparam logic [BYTE_W-1:0] ST_RD_LAST = 8'hC6;

    // completion codes left in the data register
    localparam logic [BYTE_W-1:0] CMPL_OK       = 8'h00;
    localparam logic [BYTE_W-1:0] CMPL_BAD_SEQ  = 8'h02;
    localparam logic [BYTE_W-1:0] CMPL_BAD_CODE = 8'h04;
    localparam logic [BYTE_W-1:0] CMPL_FULL     = 8'h05;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_WRITE,
        PH_WAIT,
        PH_READ
    } phase_e;

    typedef struct packed {
        phase_e            phase;
        logic [BYTE_W-1:0] status;
        logic [BYTE_W-1:0] data;
        logic [BYTE_W-1:0] ctrl;
        logic              busy;
        logic              ovf;
        logic              resp_avail;
        logic              last_sent;
    } regs_t;

endpackage

// File: rtl/smic_fifo.sv
module smic_fifo #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             push,
    input  logic [WIDTH-1:0] din,
    input  logic             pop,
    output logic [WIDTH-1:0] dout,
    output logic             empty,
    output logic             full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [WIDTH-1:0] mem_q [DEPTH];
    logic [AW-1:0]    wr_q, wr_d, rd_q, rd_d;
    logic [CW-1:0]    cnt_q, cnt_d;
    logic             do_push, do_pop;

    function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign full    = (cnt_q == CW'(DEPTH));
    assign empty   = (cnt_q == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = mem_q[rd_q];

    always_comb begin
        wr_d  = wr_q;
        rd_d  = rd_q;
        cnt_d = cnt_q;
        if (flush) begin
            wr_d  = '0;
            rd_d  = '0;
            cnt_d = '0;
        end else begin
            if (do_push) wr_d = step(wr_q);
            if (do_pop)  rd_d = step(rd_q);
            cnt_d = cnt_q + CW'(do_push) - CW'(do_pop);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_q  <= '0;
            rd_q  <= '0;
            cnt_q <= '0;
        end else begin
            wr_q  <= wr_d;
            rd_q  <= rd_d;
            cnt_q <= cnt_d;
        end
    end

    always_ff @(posedge clk) begin
        if (do_push && !flush) mem_q[wr_q] <= din;
    end
endmodule

// File: rtl/smic_latency_timer.sv
module smic_latency_timer #(
    parameter int LATENCY = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic fire
);
    localparam int CW = $clog2(LATENCY + 1);

    logic [CW-1:0] cnt_q, cnt_d;

    always_comb begin
        cnt_d = cnt_q;
        if (start)              cnt_d = CW'(LATENCY);
        else if (cnt_q != '0)   cnt_d = cnt_q - 1'b1;
    end

    assign fire = (cnt_q == CW'(1));

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/smic_responder.sv
module smic_responder
    import smic_resp_pkg::*;
#(
    parameter int RX_DEPTH = 16,
    parameter int TX_DEPTH = 16,
    parameter int LATENCY  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        host_addr,
    input  logic              host_wr,
    input  logic [BYTE_W-1:0] host_wdata,
    output logic [BYTE_W-1:0] host_rdata,
    input  logic              evt_pending,
    output logic [BYTE_W-1:0] rx_data,
    output logic              rx_valid,
    input  logic              rx_pop,
    output logic              req_end,
    input  logic [BYTE_W-1:0] tx_data,
    input  logic              tx_last,
    input  logic              tx_push,
    output logic              tx_full
);
    localparam regs_t REGS_RST = '{
        phase: PH_IDLE, status: ST_READY, data: CMPL_OK, ctrl: CC_GET,
        busy: 1'b0, ovf: 1'b0, resp_avail: 1'b0, last_sent: 1'b0
    };

    regs_t r_q, r_d;

    logic              fire, start;
    logic              rx_push, rx_flush, rx_full, rx_empty;
    logic              tx_pop, tx_flush, tx_empty;
    logic [BYTE_W:0]   tx_dout;
    logic              err_seq, err_code;
    logic              resp_rdy, accept_rdy;
    logic [BYTE_W-1:0] flags_w, status_w, data_w, ctrl_w;
    logic              busy_w;

    smic_latency_timer #(.LATENCY(LATENCY)) u_timer (
        .clk(clk), .rst_n(rst_n), .start(start), .fire(fire)
    );

    smic_fifo #(.WIDTH(BYTE_W), .DEPTH(RX_DEPTH)) u_rxq (
        .clk(clk), .rst_n(rst_n), .flush(rx_flush), .push(rx_push),
        .din(r_q.data), .pop(rx_pop), .dout(rx_data),
        .empty(rx_empty), .full(rx_full)
    );

    smic_fifo #(.WIDTH(BYTE_W + 1), .DEPTH(TX_DEPTH)) u_txq (
        .clk(clk), .rst_n(rst_n), .flush(tx_flush), .push(tx_push),
        .din({tx_last, tx_data}), .pop(tx_pop), .dout(tx_dout),
        .empty(tx_empty), .full(tx_full)
    );

    assign rx_valid   = !rx_empty;
    assign busy_w     = r_q.busy;
    assign status_w   = r_q.status;
    assign data_w     = r_q.data;
    assign ctrl_w     = r_q.ctrl;
    assign accept_rdy = !r_q.busy && !rx_full;
    assign resp_rdy   = r_q.resp_avail && !r_q.busy &&
                        (r_q.phase == PH_WAIT ||
                         (r_q.phase == PH_READ && !r_q.last_sent));
    assign flags_w    = {resp_rdy, accept_rdy, 3'b000, evt_pending, 1'b0, r_q.busy};

    always_comb begin
        case (host_addr)
            2'd0:    host_rdata = data_w;
            2'd1:    host_rdata = status_w;
            2'd2:    host_rdata = flags_w;
            default: host_rdata = '0;
        endcase
    end

    always_comb begin
        r_d      = r_q;
        start    = 1'b0;
        rx_push  = 1'b0;
        rx_flush = 1'b0;
        tx_pop   = 1'b0;
        tx_flush = 1'b0;
        req_end  = 1'b0;
        err_seq  = 1'b0;
        err_code = 1'b0;

        if (tx_push && tx_last && !tx_full) r_d.resp_avail = 1'b1;

        if (host_wr && !r_q.busy) begin
            case (host_addr)
                2'd0: r_d.data = host_wdata;
                2'd1: r_d.ctrl = host_wdata;
                2'd2: if (host_wdata[0]) begin
                    r_d.busy = 1'b1;
                    start    = 1'b1;
                end
                default: ;
            endcase
        end

        if (fire) begin
            r_d.busy   = 1'b0;
            r_d.status = r_q.ctrl | ST_MARK;
            case (r_q.ctrl)
                CC_GET: r_d.status = ST_READY;
                CC_WR_START:
                    if (r_q.phase == PH_IDLE) begin
                        rx_push   = !rx_full;
                        r_d.ovf   = rx_full;
                        r_d.phase = PH_WRITE;
                    end else err_seq = 1'b1;
                CC_WR_NEXT:
                    if (r_q.phase == PH_WRITE) begin
                        rx_push = !rx_full;
                        if (rx_full) r_d.ovf = 1'b1;
                    end else err_seq = 1'b1;
                CC_WR_END:
                    if (r_q.phase == PH_WRITE) begin
                        r_d.ovf = 1'b0;
                        if (r_q.ovf || rx_full) begin
                            r_d.data  = CMPL_FULL;
                            r_d.phase = PH_IDLE;
                            rx_flush  = 1'b1;
                        end else begin
                            rx_push   = 1'b1;
                            r_d.data  = CMPL_OK;
                            r_d.phase = PH_WAIT;
                            req_end   = 1'b1;
                        end
                    end else err_seq = 1'b1;
                CC_RD_START:
                    if (r_q.phase == PH_WAIT && r_q.resp_avail && !tx_empty) begin
                        tx_pop        = 1'b1;
                        r_d.data      = tx_dout[BYTE_W-1:0];
                        r_d.last_sent = tx_dout[BYTE_W];
                        r_d.phase     = PH_READ;
                    end else err_seq = 1'b1;
                CC_RD_NEXT:
                    if (r_q.phase == PH_READ && !r_q.last_sent && !tx_empty) begin
                        tx_pop        = 1'b1;
                        r_d.data      = tx_dout[BYTE_W-1:0];
                        r_d.last_sent = tx_dout[BYTE_W];
                        if (tx_dout[BYTE_W]) r_d.status = ST_RD_LAST;
                    end else err_seq = 1'b1;
                CC_RD_END:
                    if (r_q.phase == PH_READ && r_q.last_sent) begin
                        r_d.status     = ST_READY;
                        r_d.data       = CMPL_OK;
                        r_d.phase      = PH_IDLE;
                        r_d.resp_avail = 1'b0;
                        r_d.last_sent  = 1'b0;
                    end else err_seq = 1'b1;
                default: err_code = 1'b1;
            endcase

            if (err_seq || err_code) begin
                r_d.data       = err_code ? CMPL_BAD_CODE : CMPL_BAD_SEQ;
                r_d.phase      = PH_IDLE;
                r_d.ovf        = 1'b0;
                r_d.resp_avail = 1'b0;
                r_d.last_sent  = 1'b0;
                rx_push        = 1'b0;
                rx_flush       = 1'b1;
                tx_flush       = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= REGS_RST;
        else        r_q <= r_d;
    end
endmodule

// File: rtl/smic_responder_chk.sv
module smic_responder_chk #(
    parameter int LATENCY = 3
) (
    input logic       clk,
    input logic       rst_n,
    input logic       busy,
    input logic [7:0] flags,
    input logic [7:0] status,
    input logic [7:0] ctrl,
    input logic [7:0] data,
    input logic       host_wr,
    input logic [1:0] host_addr,
    input logic       req_end
);
    logic [15:0] busy_run;

    always_ff @(posedge clk) begin
        if (!rst_n || !busy) busy_run <= '0;
        else                 busy_run <= busy_run + 16'd1;
    end

    // R2: busy window lasts exactly LATENCY cycles
    a_r2_busy_window: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> busy_run == 16'(LATENCY));

    // R13: flags never all ones
    a_r13_flags_not_ff: assert property (@(posedge clk) disable iff (!rst_n)
        flags != 8'hFF);

    // R3: write and read-start commands echo control with bit 7 set
    a_r3_status_echo: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(busy) && ctrl inside {8'h41, 8'h42, 8'h43, 8'h44})
        |-> status == (ctrl | 8'h80));

    // R14: control writes during busy are dropped
    a_r14_ctrl_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && host_wr && host_addr == 2'd1) |=> $stable(ctrl));

    // R5: an accepted request ends with busy clear and success code
    a_r5_req_end_ok: assert property (@(posedge clk) disable iff (!rst_n)
        req_end |=> (!busy && data == 8'h00));
endmodule

bind smic_responder smic_responder_chk #(.LATENCY(LATENCY)) u_chk (
    .clk(clk), .rst_n(rst_n), .busy(busy_w), .flags(flags_w),
    .status(status_w), .ctrl(ctrl_w), .data(data_w),
    .host_wr(host_wr), .host_addr(host_addr), .req_end(req_end)
);

// File: tb/sim_smic_responder.sv
module sim_smic_responder;
    localparam int RXD = 4;
    localparam int TXD = 8;
    localparam int LAT = 5;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] host_addr = 2'd0;
    logic       host_wr = 1'b0;
    logic [7:0] host_wdata = 8'h00;
    logic [7:0] host_rdata;
    logic       evt_pending = 1'b0;
    logic [7:0] rx_data;
    logic       rx_valid;
    logic       rx_pop = 1'b0;
    logic       req_end;
    logic [7:0] tx_data = 8'h00;
    logic       tx_last = 1'b0;
    logic       tx_push = 1'b0;
    logic       tx_full;

    int n_chk = 0;
    int n_bad = 0;
    int req_cnt = 0;
    logic [7:0] busy_flags;

    always #5 clk = ~clk;

    smic_responder #(.RX_DEPTH(RXD), .TX_DEPTH(TXD), .LATENCY(LAT)) u0 (
        .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wr(host_wr),
        .host_wdata(host_wdata), .host_rdata(host_rdata),
        .evt_pending(evt_pending), .rx_data(rx_data), .rx_valid(rx_valid),
        .rx_pop(rx_pop), .req_end(req_end), .tx_data(tx_data),
        .tx_last(tx_last), .tx_push(tx_push), .tx_full(tx_full)
    );

    always @(negedge clk) if (req_end) req_cnt++;

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] v);
        host_addr = a;
        #1;
        v = host_rdata;
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] v);
        @(negedge clk);
        host_addr = a; host_wdata = v; host_wr = 1'b1;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    // write data and control, raise busy, wait for it to drop
    task automatic issue(input logic [7:0] code, input logic [7:0] b, output int lat);
        logic [7:0] f;
        wr(2'd0, b);
        wr(2'd1, code);
        wr(2'd2, 8'h01);
        lat = 0;
        rd(2'd2, f);
        busy_flags = f;
        while (f[0] && lat < 1000) begin
            lat++;
            @(negedge clk);
            rd(2'd2, f);
        end
    endtask

    task automatic push_resp(input logic [7:0] b, input logic last);
        @(negedge clk);
        tx_data = b; tx_last = last; tx_push = 1'b1;
        @(negedge clk);
        tx_push = 1'b0; tx_last = 1'b0;
    endtask

    task automatic pop_req(input string req, input logic [7:0] exp);
        @(negedge clk);
        #1;
        check(req, {7'd0, rx_valid}, 1);
        check(req, rx_data, exp);
        rx_pop = 1'b1;
        @(negedge clk);
        rx_pop = 1'b0;
    endtask

    task automatic t_reset;
        logic [7:0] v;
        @(negedge clk);
        rd(2'd1, v); check("R1 status", v, 8'hC0);
        rd(2'd0, v); check("R1 data", v, 8'h00);
        rd(2'd2, v); check("R1 flags", v, 8'h40);
        evt_pending = 1'b1;
        rd(2'd2, v); check("R13 pending flag", v, 8'h44);
        evt_pending = 1'b0;
    endtask

    task automatic t_flag_write_ignored;
        logic [7:0] v;
        wr(2'd2, 8'hFE);
        @(negedge clk);
        rd(2'd2, v); check("R2 flags write without bit0", v, 8'h40);
    endtask

    task automatic t_get_status;
        int lat; logic [7:0] v;
        issue(8'h40, 8'h00, lat);
        check("R2 busy length", lat, LAT);
        rd(2'd1, v); check("R11 get status", v, 8'hC0);
    endtask

    task automatic t_full_exchange;
        int lat; logic [7:0] v;
        int r0;
        r0 = req_cnt;
        issue(8'h41, 8'hA1, lat);
        check("R4 accept-ready low while busy", busy_flags[6], 0);
        rd(2'd1, v); check("R3 write-start status", v, 8'hC1);
        issue(8'h40, 8'h00, lat);
        rd(2'd1, v); check("R11 get status mid-write", v, 8'hC0);
        issue(8'h42, 8'hA2, lat);
        rd(2'd1, v); check("R3 write-next status", v, 8'hC2);
        issue(8'h43, 8'hA3, lat);
        rd(2'd1, v); check("R3 write-end status", v, 8'hC3);
        rd(2'd0, v); check("R5 completion ok", v, 8'h00);
        check("R5 req_end pulses", req_cnt - r0, 1);
        pop_req("R4 byte0", 8'hA1);
        pop_req("R4 byte1", 8'hA2);
        pop_req("R4 byte2", 8'hA3);
        push_resp(8'hB1, 1'b0);
        push_resp(8'hB2, 1'b0);
        rd(2'd2, v); check("R8 response-ready before last", v[7], 0);
        push_resp(8'hB3, 1'b1);
        rd(2'd2, v); check("R8 response-ready after last", v[7], 1);
        issue(8'h44, 8'h00, lat);
        rd(2'd1, v); check("R3 read-start status", v, 8'hC4);
        rd(2'd0, v); check("R9 first byte", v, 8'hB1);
        issue(8'h45, 8'h00, lat);
        rd(2'd1, v); check("R9 read-next more", v, 8'hC5);
        rd(2'd0, v); check("R9 second byte", v, 8'hB2);
        issue(8'h45, 8'h00, lat);
        rd(2'd1, v); check("R9 read-next last", v, 8'hC6);
        rd(2'd0, v); check("R9 last byte", v, 8'hB3);
        issue(8'h46, 8'h00, lat);
        rd(2'd1, v); check("R10 read-end status", v, 8'hC0);
        rd(2'd0, v); check("R10 read-end data", v, 8'h00);
        rd(2'd2, v); check("R10 response-ready cleared", v[7], 0);
    endtask

    task automatic t_overflow;
        int lat; logic [7:0] v;
        int r0;
        r0 = req_cnt;
        issue(8'h41, 8'h10, lat);
        issue(8'h42, 8'h11, lat);
        issue(8'h42, 8'h12, lat);
        issue(8'h42, 8'h13, lat);
        rd(2'd2, v); check("R4 accept-ready low when full", v[6], 0);
        issue(8'h42, 8'h14, lat);
        issue(8'h43, 8'h15, lat);
        rd(2'd0, v); check("R6 buffer full code", v, 8'h05);
        check("R6 no req_end", req_cnt - r0, 0);
        check("R6 rx flushed", {7'd0, rx_valid}, 0);
    endtask

    task automatic t_bad_sequence;
        int lat; logic [7:0] v;
        issue(8'h45, 8'h00, lat);
        rd(2'd1, v); check("R12 status echo", v, 8'hC5);
        rd(2'd0, v); check("R12 illegal control in idle", v, 8'h02);
        issue(8'h41, 8'h77, lat);
        issue(8'h44, 8'h00, lat);
        rd(2'd0, v); check("R12 read-start mid-write", v, 8'h02);
        @(negedge clk); #1;
        check("R12 rx flushed", {7'd0, rx_valid}, 0);
        issue(8'h42, 8'h00, lat);
        rd(2'd0, v); check("R12 back in idle", v, 8'h02);
    endtask

    task automatic t_bad_code;
        int lat; logic [7:0] v;
        issue(8'h4F, 8'h00, lat);
        rd(2'd1, v); check("R7 unknown code status", v, 8'hCF);
        rd(2'd0, v); check("R7 unknown code data", v, 8'h04);
    endtask

    task automatic t_busy_writes;
        logic [7:0] f, v;
        int lat;
        wr(2'd0, 8'h5A);
        wr(2'd1, 8'h41);
        wr(2'd2, 8'h01);
        wr(2'd0, 8'h99);
        wr(2'd1, 8'h46);
        lat = 0;
        rd(2'd2, f);
        while (f[0] && lat < 1000) begin
            lat++;
            @(negedge clk);
            rd(2'd2, f);
        end
        rd(2'd1, v); check("R14 control write ignored", v, 8'hC1);
        pop_req("R14 data write ignored", 8'h5A);
        issue(8'h46, 8'h00, lat);
        rd(2'd0, v); check("R12 read-end mid-write", v, 8'h02);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_flag_write_ignored();
        t_get_status();
        t_full_exchange();
        t_overflow();
        t_bad_sequence();
        t_bad_code();
        t_busy_writes();
        t_full_exchange();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule